// File: doc/BRIEF.md
# Serial Transmitter with Block Fetch Channel

This block is the transmit side of a memory-mapped serial port. It has a small channel that fetches data from memory on its own. Software writes 32-bit words over a write-only register bus, and the word index (address bits above the byte offset) selects the target.

Software has two ways to send data:
- A single character written to the character register goes straight to the serial shifter.
- For a block, software first loads a byte address into the transmit pointer register and then writes a byte count. The block then reads that many consecutive bytes from memory, one at a time, over a valid/ready request port with a separate response strobe. It sends each byte as an 8N1 frame, LSB first, with a fixed clock divider. When the block ends, the pointer register returns to zero.

The block also keeps a receive pointer and drives a receive-ready flag. That flag is derived from the last value written to the receive count register. The receive data path itself is not part of this block.

Top module: `ptr_uart_tx`

## Requirements
- R1: While reset is applied and after it is released, `txd` is high and `tx_busy`, `rx_ready` and `mem_req_valid` are low. `rx_ptr` is zero.
- R2: A write to word index 0x7 while idle sends `bus_wdata[7:0]` as one frame and ignores the upper data bits. The frame is a low start bit, eight data bits LSB first, and a high stop bit. Each bit lasts `BAUD_DIV` clock cycles, and the line is high between frames.
- R3: `tx_busy` rises on the edge that accepts a character or block write. It stays high until the last stop-bit cycle of the last frame has completed. Character, pointer and count writes that arrive while `tx_busy` is high are dropped. This includes a write on the final stop-bit cycle.
- R4: Word index 0xE loads the byte pointer. Word index 0xF takes a count N from `bus_wdata[CNT_W-1:0]`. With a nonzero pointer P and N > 0, the block fetches the bytes at P, P+1, …, P+N-1 and transmits them in that order.
- R5: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. No new request is raised before `mem_rsp_valid` returns the data for the previous one.
- R6: A count write made while the pointer is zero sends nothing and issues no memory request.
- R7: At the end of a block, and on any count write that does not start a block, the pointer is cleared to zero. A later count write without a new pointer write sends nothing.
- R8: A write to word index 0xD sets `rx_ready` to 1 when the full written word is nonzero, and to 0 when it is zero.
- R9: A write to word index 0xC places `bus_wdata[PTR_W-1:0]` on `rx_ptr`.
- R10: Writes to word indices 0x8, 0xA, 0xB and to any other index not listed above change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] are the word index |
| bus_wdata | input | DATA_W | Register write data |
| mem_req_valid | output | 1 | Byte read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PTR_W | Byte address of the pending request |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 8 | Read data byte |
| txd | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Character or block transmission in progress |
| rx_ready | output | 1 | Receive-ready flag |
| rx_ptr | output | PTR_W | Stored receive pointer |

## Verification
A new software write can coincide with the shifter finishing its last stop bit. That write samples a busy flag that is about to fall. The bench provokes this with a character write placed exactly on the final stop-bit cycle, which must be dropped, followed by a second write on the very next cycle, which must be accepted. It judges the outcome by decoding the serial line: only the second character may follow the first, and `tx_busy` is sampled on both cycles. A second overlap is tested by issuing character and count writes while a block fetch is in flight. Both must leave the memory request log and the decoded byte stream unchanged.

// File: rtl/ptr_uart_tx_pkg.sv
package ptr_uart_tx_pkg;

  // word indices decoded from the register bus
  localparam int unsigned IDX_CHAR   = 32'h7;
  localparam int unsigned IDX_RX_PTR = 32'hC;
  localparam int unsigned IDX_RX_CNT = 32'hD;
  localparam int unsigned IDX_TX_PTR = 32'hE;
  localparam int unsigned IDX_TX_CNT = 32'hF;

  // serial frame: start + 8 data + stop
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WAIT,
    SQ_SEND
  } seq_state_e;

endpackage

// File: rtl/ptr_uart_tx_dec.sv
module ptr_uart_tx_dec
  import ptr_uart_tx_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_busy,
  output logic              char_go,
  output logic              txptr_wr,
  output logic              txcnt_wr,
  output logic              rx_ready,
  output logic [PTR_W-1:0]  rx_ptr
);

  logic             hit_char, hit_rxptr, hit_rxcnt, hit_txptr, hit_txcnt;
  logic             rx_ready_n;
  logic [PTR_W-1:0] rx_ptr_n;

  always_comb begin
    hit_char  = wr_en && (int'(idx) == IDX_CHAR);
    hit_rxptr = wr_en && (int'(idx) == IDX_RX_PTR);
    hit_rxcnt = wr_en && (int'(idx) == IDX_RX_CNT);
    hit_txptr = wr_en && (int'(idx) == IDX_TX_PTR);
    hit_txcnt = wr_en && (int'(idx) == IDX_TX_CNT);
    char_go   = hit_char  && !tx_busy;
    txptr_wr  = hit_txptr && !tx_busy;
    txcnt_wr  = hit_txcnt && !tx_busy;
  end

  always_comb begin
    rx_ready_n = rx_ready;
    rx_ptr_n   = rx_ptr;
    if (hit_rxcnt) rx_ready_n = (wdata != '0);
    if (hit_rxptr) rx_ptr_n   = wdata[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      rx_ptr   <= '0;
    end else if (hit_rxcnt || hit_rxptr) begin
      rx_ready <= rx_ready_n;
      rx_ptr   <= rx_ptr_n;
    end
  end

  // R8: flag follows the zero test of the written word
  a_r8_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(idx) == IDX_RX_CNT) |=> (rx_ready == ($past(wdata) != '0)));

  // R9: receive pointer captures the written word
  a_r9_rx_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(idx) == IDX_RX_PTR) |=> (rx_ptr == $past(wdata[PTR_W-1:0])));

endmodule

// File: rtl/ptr_uart_tx_seq.sv
module ptr_uart_tx_seq
  import ptr_uart_tx_pkg::*;
#(
  parameter int unsigned PTR_W = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PTR_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [7:0]       mem_rsp_data,
  input  logic             sh_busy,
  output logic             sh_load,
  output logic [7:0]       sh_byte,
  output logic             active
);

  seq_state_e       state, state_n;
  logic [PTR_W-1:0] ptr, ptr_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [7:0]       byte_q, byte_n;

  always_comb begin
    state_n = state;
    ptr_n   = ptr;
    cnt_n   = cnt;
    byte_n  = byte_q;
    sh_load = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (ptr_wr) ptr_n = ptr_wdata;
        if (cnt_wr) begin
          if (ptr != '0 && cnt_wdata != '0) begin
            cnt_n   = cnt_wdata;
            state_n = SQ_REQ;
          end else begin
            ptr_n = '0;
          end
        end
      end
      SQ_REQ: begin
        if (mem_req_ready) state_n = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (mem_rsp_valid) begin
          byte_n  = mem_rsp_data;
          state_n = SQ_SEND;
        end
      end
      SQ_SEND: begin
        if (!sh_busy) begin
          sh_load = 1'b1;
          cnt_n   = cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            ptr_n   = '0;
            state_n = SQ_IDLE;
          end else begin
            ptr_n   = ptr + 1'b1;
            state_n = SQ_REQ;
          end
        end
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      ptr    <= '0;
      cnt    <= '0;
      byte_q <= '0;
    end else begin
      state  <= state_n;
      ptr    <= ptr_n;
      cnt    <= cnt_n;
      byte_q <= byte_n;
    end
  end

  always_comb begin
    mem_req_valid = (state == SQ_REQ);
    mem_req_addr  = ptr;
    sh_byte       = byte_q;
    active        = (state != SQ_IDLE);
  end

  // R5: request held steady until accepted
  a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R5: a response only arrives while one fetch is outstanding
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state == SQ_WAIT));

  // R6: zero pointer keeps the channel idle
  a_r6_zero_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && ptr == '0) |=> (state == SQ_IDLE && ptr == '0));

  // R7: pointer reads zero once a block has finished
  a_r7_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (ptr == '0));

endmodule

// File: rtl/ptr_uart_tx_shift.sv
module ptr_uart_tx_shift
  import ptr_uart_tx_pkg::*;
#(
  parameter int unsigned BAUD_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       busy,
  output logic       txd
);

  localparam int unsigned DIV_W = (BAUD_DIV > 2) ? $clog2(BAUD_DIV) : 1;
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic                  busy_n;
  logic [FRAME_BITS-1:0] sreg, sreg_n;
  logic [DIV_W-1:0]      div_cnt, div_n;
  logic [BIT_W-1:0]      bit_cnt, bit_n;
  logic                  en;

  always_comb begin
    busy_n = busy;
    sreg_n = sreg;
    div_n  = div_cnt;
    bit_n  = bit_cnt;
    if (load) begin
      busy_n = 1'b1;
      sreg_n = {1'b1, byte_in, 1'b0};
      div_n  = '0;
      bit_n  = '0;
    end else if (busy) begin
      if (div_cnt == DIV_W'(BAUD_DIV - 1)) begin
        div_n = '0;
        if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
          busy_n = 1'b0;
        end else begin
          bit_n  = bit_cnt + 1'b1;
          sreg_n = {1'b1, sreg[FRAME_BITS-1:1]};
        end
      end else begin
        div_n = div_cnt + 1'b1;
      end
    end
  end

  assign en = load || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sreg    <= '1;
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (en) begin
      busy    <= busy_n;
      sreg    <= sreg_n;
      div_cnt <= div_n;
      bit_cnt <= bit_n;
    end
  end

  assign txd = busy ? sreg[0] : 1'b1;

  // R3: nobody reloads the shifter mid-frame
  a_r3_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R2: frame never runs past its stop bit, and the stop bit is high
  a_r2_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(bit_cnt) < FRAME_BITS));

  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(bit_cnt) == FRAME_BITS - 1) |-> txd);

endmodule

// File: rtl/ptr_uart_tx.sv
module ptr_uart_tx #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PTR_W    = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned BAUD_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PTR_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              txd,
  output logic              tx_busy,
  output logic              rx_ready,
  output logic [PTR_W-1:0]  rx_ptr
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [1:0] rst_sync;
  logic       rst_i_n;
  logic       unused_lo;
  logic       char_go, txptr_wr, txcnt_wr;
  logic       seq_load, seq_active, sh_busy, sh_load;
  logic [7:0] seq_byte, sh_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n   = rst_sync[1];
  assign unused_lo = ^bus_addr[1:0];

  ptr_uart_tx_dec #(.IDX_W(IDX_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (bus_wr),
    .idx      (bus_addr[ADDR_W-1:2]),
    .wdata    (bus_wdata),
    .tx_busy  (tx_busy),
    .char_go  (char_go),
    .txptr_wr (txptr_wr),
    .txcnt_wr (txcnt_wr),
    .rx_ready (rx_ready),
    .rx_ptr   (rx_ptr)
  );

  ptr_uart_tx_seq #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .ptr_wr        (txptr_wr),
    .ptr_wdata     (bus_wdata[PTR_W-1:0]),
    .cnt_wr        (txcnt_wr),
    .cnt_wdata     (bus_wdata[CNT_W-1:0]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .sh_busy       (sh_busy),
    .sh_load       (seq_load),
    .sh_byte       (seq_byte),
    .active        (seq_active)
  );

  assign sh_load = char_go || seq_load;
  assign sh_byte = char_go ? bus_wdata[7:0] : seq_byte;
  assign tx_busy = seq_active || sh_busy;

  ptr_uart_tx_shift #(.BAUD_DIV(BAUD_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load    (sh_load),
    .byte_in (sh_byte),
    .busy    (sh_busy),
    .txd     (txd)
  );

  // R3: a software character never competes with a fetched byte
  a_r3_single_source: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(char_go && seq_load));

  // R1: quiet outputs while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_i_n |-> (txd && !tx_busy && !mem_req_valid && !rx_ready));

endmodule

// File: tb/ptr_uart_tx_tb.sv
module ptr_uart_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int AW         = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, rx_ptr;
  logic [7:0]  mem_rsp_data;
  logic        txd, tx_busy, rx_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_uart_tx #(.ADDR_W(AW), .DATA_W(32), .PTR_W(32), .CNT_W(16), .BAUD_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .txd(txd), .tx_busy(tx_busy), .rx_ready(rx_ready), .rx_ptr(rx_ptr)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // character vectors: written word and expected line byte (R2)
  localparam logic [31:0] VEC_W [6] = '{32'hDEAD_BE55, 32'h0000_00A3, 32'hFFFF_FF00,
                                        32'h1234_56FF, 32'h0000_0181, 32'h8000_003C};
  localparam logic [7:0]  VEC_E [6] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // serial line decoder
  logic [7:0] rx_log [64];
  int rx_n = 0;
  int frame_err = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [7:0] b;
        repeat (DIV/2) @(negedge clk);
        if (txd !== 1'b0) frame_err++;
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = txd;
        end
        repeat (DIV) @(negedge clk);
        if (txd !== 1'b1) frame_err++;
        if (rx_n < 64) rx_log[rx_n] = b;
        rx_n++;
      end
    end
  end

  // memory model: accepts after a stall, answers a few cycles later
  logic [31:0] req_log [32];
  int req_n = 0;
  int viol = 0;
  initial begin
    int pend = 0;
    int stall = 0;
    logic [31:0] last_a = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (pend > 0) begin
        if (mem_req_valid === 1'b1) viol++;
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pat(last_a);
        end
      end else if (mem_req_valid === 1'b1) begin
        stall++;
        if (stall >= 2) begin
          mem_req_ready = 1'b1;
          last_a = mem_req_addr;
          if (req_n < 32) req_log[req_n] = mem_req_addr;
          req_n++;
          pend  = 3;
          stall = 0;
        end
      end
    end
  end

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = 12'(idx << 2);
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    for (int i = 0; i < 4000 && rx_n < target; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && tx_busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, rq;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 txd in reset", 32'(txd), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd === 1'b1, "R1 txd", 32'(txd), 1);
    chk(tx_busy === 1'b0, "R1 busy", 32'(tx_busy), 0);
    chk(rx_ready === 1'b0, "R1 rx_ready", 32'(rx_ready), 0);
    chk(mem_req_valid === 1'b0, "R1 req", 32'(mem_req_valid), 0);
    chk(rx_ptr === 32'h0, "R1 rx_ptr", rx_ptr, 0);

    // vector table: single characters (R2, R3)
    for (int v = 0; v < 6; v++) begin
      base = rx_n;
      bus_write(7, VEC_W[v]);
      chk(tx_busy === 1'b1, "R3 busy after char", 32'(tx_busy), 1);
      wait_rx(base + 1);
      chk(rx_n == base + 1 && rx_log[base] === VEC_E[v], "R2 char byte", 32'(rx_log[base]), 32'(VEC_E[v]));
      wait_idle();
    end
    chk(frame_err == 0, "R2 start/stop levels", frame_err, 0);

    // write landing on the last stop-bit cycle is dropped, next cycle is taken (R3)
    base = rx_n;
    bus_write(7, 32'h0000_0069);
    repeat (10*DIV - 1) @(negedge clk);
    chk(tx_busy === 1'b1, "R3 busy on final stop cycle", 32'(tx_busy), 1);
    bus_wr = 1'b1; bus_addr = 12'(7 << 2); bus_wdata = 32'h0000_00E7;
    @(negedge clk);
    chk(tx_busy === 1'b0, "R3 busy after frame", 32'(tx_busy), 0);
    bus_wdata = 32'h0000_004B;
    @(negedge clk);
    bus_wr = 1'b0;
    wait_rx(base + 2);
    wait_idle();
    repeat (3*DIV*10) @(negedge clk);
    chk(rx_n == base + 2, "R3 dropped write count", rx_n - base, 2);
    chk(rx_log[base+1] === 8'h4B, "R3 accepted next cycle", 32'(rx_log[base+1]), 32'h4B);

    // block transfer with busy-time intrusions (R4, R5, R3)
    base = rx_n; rq = req_n;
    bus_write(14, 32'h0000_0100);
    bus_write(15, 32'h0003_0005);
    wait_rx(base + 1);
    bus_write(7, 32'h0000_0077);
    bus_write(15, 32'h0000_0003);
    bus_write(14, 32'h0000_0400);
    wait_rx(base + 5);
    wait_idle();
    repeat (300) @(negedge clk);
    chk(rx_n == base + 5, "R3 block byte count", rx_n - base, 5);
    chk(req_n == rq + 5, "R4 request count", req_n - rq, 5);
    for (int i = 0; i < 5; i++) begin
      chk(req_log[rq+i] === 32'h100 + 32'(i), "R4 fetch address", req_log[rq+i], 32'h100 + 32'(i));
      chk(rx_log[base+i] === pat(32'h100 + 32'(i)), "R4 byte order", 32'(rx_log[base+i]), 32'(pat(32'h100 + 32'(i))));
    end
    chk(viol == 0, "R5 single outstanding", viol, 0);

    // pointer cleared after the block (R7)
    base = rx_n; rq = req_n;
    bus_write(15, 32'h0000_0002);
    repeat (200) @(negedge clk);
    chk(rx_n == base && req_n == rq, "R7 no send after block", rx_n - base, 0);

    // zero pointer (R6)
    bus_write(14, 32'h0000_0000);
    bus_write(15, 32'h0000_0004);
    repeat (200) @(negedge clk);
    chk(rx_n == base && req_n == rq, "R6 zero pointer", req_n - rq, 0);
    chk(tx_busy === 1'b0, "R6 busy stays low", 32'(tx_busy), 0);

    // count of zero clears the pointer (R7)
    bus_write(14, 32'h0000_0040);
    bus_write(15, 32'hFFFF_0000);
    bus_write(15, 32'h0000_0001);
    repeat (200) @(negedge clk);
    chk(rx_n == base && req_n == rq, "R7 zero count clears", req_n - rq, 0);

    // block across a byte-address carry (R4)
    bus_write(14, 32'h0000_02FF);
    bus_write(15, 32'h0000_0002);
    wait_rx(base + 2);
    wait_idle();
    chk(req_log[rq] === 32'h2FF && req_log[rq+1] === 32'h300, "R4 carry address", req_log[rq+1], 32'h300);
    chk(rx_log[base] === 8'h5A && rx_log[base+1] === 8'hA5, "R4 carry bytes", 32'(rx_log[base+1]), 32'hA5);

    // receive registers (R8, R9)
    bus_write(13, 32'h0000_0005);
    @(negedge clk);
    chk(rx_ready === 1'b1, "R8 nonzero sets", 32'(rx_ready), 1);
    bus_write(13, 32'h0000_0000);
    @(negedge clk);
    chk(rx_ready === 1'b0, "R8 zero clears", 32'(rx_ready), 0);
    bus_write(13, 32'h0001_0000);
    @(negedge clk);
    chk(rx_ready === 1'b1, "R8 upper bits count", 32'(rx_ready), 1);
    bus_write(12, 32'hCAFE_1234);
    @(negedge clk);
    chk(rx_ptr === 32'hCAFE_1234, "R9 rx pointer", rx_ptr, 32'hCAFE_1234);

    // ignored indices (R10)
    base = rx_n; rq = req_n;
    bus_write(8,  32'hFFFF_FFFF);
    bus_write(10, 32'h0000_0000);
    bus_write(11, 32'h5555_5555);
    bus_write(3,  32'h0000_0041);
    begin
      int lows = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || tx_busy !== 1'b0 || mem_req_valid !== 1'b0) lows++;
      end
      chk(lows == 0, "R10 line and channel quiet", lows, 0);
    end
    chk(rx_ready === 1'b1 && rx_ptr === 32'hCAFE_1234, "R10 receive state kept", rx_ptr, 32'hCAFE_1234);
    chk(rx_n == base && req_n == rq, "R10 nothing sent", rx_n - base, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule